// File: doc/BRIEF.md
# Banked Register File with Pointer-Based Indirect Access

This block is the byte-wide data memory of a small microcontroller core. It holds a 256-byte address space seen as sixteen banks of sixteen bytes, of which bank 0 doubles as the always-visible global area. An instruction names a register through a 5-bit field. Field values below 16 reach the global area. Field values of 16 and up reach the bank chosen by the upper nibble of an 8-bit pointer register. Field value 0 is a pseudo-register that forwards the access to the full 8-bit address held in the pointer.

The pointer is itself visible as global slot 4. It can also be changed by dedicated operations: a two-cycle literal load, single-bit set and clear, increment, and a one-cycle bank select that rewrites only the three lower bank bits. The top bank bit chooses between the lower and upper group of eight banks and stays untouched by bank select. Global slots 1 and 2 hold the timer byte and the low program-counter byte as plain storage. Reads are combinational. Writes, clears and pointer changes take effect at the rising clock edge.

Top module: `bank_regfile`

## Requirements
- R1: With `rst_n` low at a rising edge, the pointer becomes 0x00 and any literal load in progress is dropped.
- R2: A field value 0x01..0x0F addresses global byte 0x01..0x0F, whatever the pointer holds.
- R3: A field value 0x10..0x1F addresses byte {pointer[7:4], field[3:0]}.
- R4: Field value 0x00 addresses the byte whose full address is the pointer value.
- R5: Effective address 0x00 (indirect with pointer 0x00, or banked with bank 0 and index 0) reads as 0x00, and writes and clears to it are dropped.
- R6: Effective address 0x04 is the pointer: a read returns it, and a write or clear to it updates it at the edge. Slots 0x01 and 0x02 keep written bytes like any other storage.
- R7: `ptr_op` codes are 0 idle, 1 load, 2 set bit, 3 clear bit, 4 increment and 5 bank select, with 6 and 7 acting as idle. Load leaves the pointer unchanged after its first edge and sets it to the `ptr_arg` value at the second edge. Any pointer operation or slot-4 write presented in that second cycle is ignored.
- R8: Bank select sets pointer bits 6..4 to `ptr_arg[2:0]` in one edge and leaves bit 7 and bits 3..0 unchanged.
- R9: Set bit and clear bit force pointer bit `ptr_arg[2:0]` to 1 or 0 in one edge and leave the other bits unchanged.
- R10: Increment adds one to the pointer modulo 256, so 0xFF becomes 0x00.
- R11: When a pointer operation and a write to slot 0x04 fall in the same cycle, the pointer operation decides the new value.
- R12: `clr_en` writes 0x00 to the effective address and wins over `wr_en` in the same cycle.
- R13: This loop clears every byte whose address has bit 4 set, leaves all other bytes unchanged, and ends with the pointer at 0x10 after 128 rounds. The pointer is loaded with 0x10, then each round clears through field 0 with an increment in the same cycle, and sets pointer bit 4 in the next cycle.
- R14: `rd_data` follows `dir_addr` and the pointer in the same cycle, with no register on the read path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_addr | input | 5 | Register field from the instruction |
| wr_en | input | 1 | Write `wr_data` to the effective address |
| clr_en | input | 1 | Write zero to the effective address |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte at the effective address |
| ptr_op | input | 3 | Pointer operation code |
| ptr_arg | input | 8 | Literal, bit index or bank number for `ptr_op` |
| ptr_q | output | 8 | Current pointer value |

## Verification
The bench builds the block with its default parameters: 8-bit data, 4-bit bank number and 4-bit register index, which gives the full 256-byte space and a 5-bit field. With these values the increment wrap from 0xFF to 0x00 and the bank select with the group bit already set are both reachable. The complete clear loop over all 128 bytes with bit 4 set can run in a few thousand cycles, after which every address is read back through the pointer.

// File: rtl/brf_pkg.sv
// Shared definitions for the banked register file.
// Assumes the fixed slot numbers below lie inside the global area.
package brf_pkg;

    // Pointer operation codes as presented on ptr_op.
    typedef enum logic [2:0] {
        PTR_IDLE = 3'd0,
        PTR_LOAD = 3'd1,
        PTR_SETB = 3'd2,
        PTR_CLRB = 3'd3,
        PTR_INC  = 3'd4,
        PTR_BANK = 3'd5
    } ptr_op_e;

    // Fixed global slots.
    localparam int unsigned SLOT_IND = 0;  // indirect pseudo-register
    localparam int unsigned SLOT_TMR = 1;  // timer byte, plain storage
    localparam int unsigned SLOT_PCL = 2;  // low program-counter byte, plain storage
    localparam int unsigned SLOT_PTR = 4;  // pointer register

endpackage

// File: rtl/brf_addr_decode.sv
// Effective-address decoder.
// Turns the instruction's register field and the pointer into a full address.
// Flags the null slot and the pointer slot. Purely combinational.
// Assumes FIELD_W == IDX_W + 1.
module brf_addr_decode #(
    parameter int IDX_W  = 4,
    parameter int BANK_W = 4,
    localparam int ADDR_W  = IDX_W + BANK_W,
    localparam int FIELD_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] dir_addr_i,
    input  logic [ADDR_W-1:0]  ptr_i,
    output logic [ADDR_W-1:0]  eff_addr_o,
    output logic               eff_null_o,
    output logic               eff_is_ptr_o
);
    import brf_pkg::*;

    logic banked;
    logic [IDX_W-1:0] idx;

    assign banked = dir_addr_i[FIELD_W-1];
    assign idx    = dir_addr_i[IDX_W-1:0];

    // Pick banked, indirect or global address.
    always_comb begin
        if (banked) begin
            eff_addr_o = {ptr_i[ADDR_W-1:IDX_W], idx};
        end else if (idx == '0) begin
            eff_addr_o = ptr_i;
        end else begin
            eff_addr_o = {{BANK_W{1'b0}}, idx};
        end
    end

    // Classify the special slots.
    always_comb begin
        eff_null_o   = (eff_addr_o == ADDR_W'(SLOT_IND));
        eff_is_ptr_o = (eff_addr_o == ADDR_W'(SLOT_PTR));
    end

    // R5
    null_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eff_null_o |-> ((dir_addr_i == '0) ? (ptr_i == '0)
                        : (banked && idx == '0 && ptr_i[ADDR_W-1:IDX_W] == '0)));

    // R2
    global_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!banked && idx != '0) |-> (eff_addr_o < ADDR_W'(1 << IDX_W) && !eff_null_o));

endmodule

// File: rtl/brf_ptr_reg.sv
// Pointer register.
// Holds the 8-bit indirect address and applies load, bit set/clear, increment
// and bank select. A literal load is staged for one cycle and committed at the
// next edge. Pointer operations win over writes through the pointer slot.
// Assumes BANK_W >= 2 so that a group bit exists above the bank-select bits.
module brf_ptr_reg #(
    parameter int IDX_W  = 4,
    parameter int BANK_W = 4,
    localparam int ADDR_W = IDX_W + BANK_W,
    localparam int BSEL_W = BANK_W - 1,
    localparam int BIT_W  = $clog2(ADDR_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  brf_pkg::ptr_op_e      op_i,
    input  logic [ADDR_W-1:0]     arg_i,
    input  logic                  slot_we_i,
    input  logic [ADDR_W-1:0]     slot_wdata_i,
    output logic [ADDR_W-1:0]     ptr_o
);
    import brf_pkg::*;

    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic [ADDR_W-1:0] stage_q, stage_d;
    logic              pend_q, pend_d;

    // Next pointer, staging value and pending flag.
    always_comb begin
        ptr_d   = ptr_q;
        stage_d = stage_q;
        pend_d  = 1'b0;
        if (pend_q) begin
            ptr_d = stage_q;
        end else begin
            case (op_i)
                PTR_LOAD: begin
                    stage_d = arg_i;
                    pend_d  = 1'b1;
                end
                PTR_SETB: ptr_d[arg_i[BIT_W-1:0]] = 1'b1;
                PTR_CLRB: ptr_d[arg_i[BIT_W-1:0]] = 1'b0;
                PTR_INC:  ptr_d = ptr_q + 1'b1;
                PTR_BANK: ptr_d[ADDR_W-2:IDX_W] = arg_i[BSEL_W-1:0];
                default:  if (slot_we_i) ptr_d = slot_wdata_i;
            endcase
        end
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            stage_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            ptr_q   <= ptr_d;
            stage_q <= stage_d;
            pend_q  <= pend_d;
        end
    end

    assign ptr_o = ptr_q;

    // R7
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PTR_LOAD && !pend_q) |=> (ptr_q == $past(ptr_q) && pend_q));

    // R7
    load_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> (ptr_q == $past(stage_q) && !pend_q));

    // R8
    bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PTR_BANK && !pend_q) |=>
            (ptr_q[ADDR_W-1] == $past(ptr_q[ADDR_W-1])
             && ptr_q[IDX_W-1:0] == $past(ptr_q[IDX_W-1:0])
             && ptr_q[ADDR_W-2:IDX_W] == $past(arg_i[BSEL_W-1:0])));

    // R9
    setb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PTR_SETB && !pend_q) |=>
            ($countones(ptr_q ^ $past(ptr_q)) <= 1 && (ptr_q & ~$past(ptr_q)) == (ptr_q ^ $past(ptr_q))));

    // R10
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PTR_INC && !pend_q && ptr_q == '1) |=> (ptr_q == '0));

endmodule

// File: rtl/brf_store.sv
// Byte storage for every address of the space except the null slot and the
// pointer slot, which hold no cells here. One write port and one
// combinational read port. The caller keeps writes away from the two
// excluded slots.
module brf_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    import brf_pkg::*;

    logic [DATA_W-1:0] cell_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        if (g == SLOT_IND || g == SLOT_PTR) begin : g_none
            assign cell_q[g] = '0;
        end else begin : g_byte
            logic [DATA_W-1:0] q;
            // Capture the byte when this address is written.
            always_ff @(posedge clk) begin
                if (we_i && addr_i == ADDR_W'(g)) q <= wdata_i;
            end
            assign cell_q[g] = q;
        end
    end

    assign rdata_o = cell_q[addr_i];

    // R5
    no_special_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (addr_i != ADDR_W'(SLOT_IND) && addr_i != ADDR_W'(SLOT_PTR)));

endmodule

// File: rtl/bank_regfile.sv
// Banked register file top.
// Joins the address decoder, the pointer register and the byte store.
// Routes writes either to storage or to the pointer and merges the read
// sources. Assumes DATA_W >= IDX_W + BANK_W so the pointer fits a data byte.
module bank_regfile #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4,
    parameter int BANK_W = 4,
    localparam int ADDR_W  = IDX_W + BANK_W,
    localparam int FIELD_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] dir_addr,
    input  logic               wr_en,
    input  logic               clr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [2:0]         ptr_op,
    input  logic [ADDR_W-1:0]  ptr_arg,
    output logic [ADDR_W-1:0]  ptr_q
);
    import brf_pkg::*;

    logic [ADDR_W-1:0] eff_addr;
    logic              eff_null, eff_is_ptr;
    logic              wr_any, store_we, slot_we;
    logic [DATA_W-1:0] wdata_eff, store_rdata, ptr_ext;
    ptr_op_e           op_c;

    assign op_c = ptr_op_e'(ptr_op);

    brf_addr_decode #(.IDX_W(IDX_W), .BANK_W(BANK_W)) dec_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dir_addr_i  (dir_addr),
        .ptr_i       (ptr_q),
        .eff_addr_o  (eff_addr),
        .eff_null_o  (eff_null),
        .eff_is_ptr_o(eff_is_ptr)
    );

    // Route a write or clear to storage or to the pointer slot.
    always_comb begin
        wr_any    = wr_en | clr_en;
        wdata_eff = clr_en ? '0 : wr_data;
        store_we  = wr_any && !eff_null && !eff_is_ptr;
        slot_we   = wr_any && eff_is_ptr;
    end

    brf_ptr_reg #(.IDX_W(IDX_W), .BANK_W(BANK_W)) ptr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op_c),
        .arg_i       (ptr_arg),
        .slot_we_i   (slot_we),
        .slot_wdata_i(wdata_eff[ADDR_W-1:0]),
        .ptr_o       (ptr_q)
    );

    brf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (store_we),
        .addr_i (eff_addr),
        .wdata_i(wdata_eff),
        .rdata_o(store_rdata)
    );

    // Widen the pointer to a data byte.
    always_comb begin
        ptr_ext = '0;
        ptr_ext[ADDR_W-1:0] = ptr_q;
    end

    // Merge the read sources.
    always_comb begin
        if (eff_null)        rd_data = '0;
        else if (eff_is_ptr) rd_data = ptr_ext;
        else                 rd_data = store_rdata;
    end

    // R12
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && eff_is_ptr && op_c == PTR_IDLE && ptr_q != '0) |=> (ptr_q == '0 || $past(ptr_q) == ptr_q));

endmodule

// File: tb/bank_regfile_tb.sv
module bank_regfile_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] dir_addr = '0;
    logic       wr_en = 1'b0;
    logic       clr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [2:0] ptr_op = '0;
    logic [7:0] ptr_arg = '0;
    logic [7:0] ptr_q;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bank_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .dir_addr(dir_addr), .wr_en(wr_en),
        .clr_en(clr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ptr_op(ptr_op), .ptr_arg(ptr_arg), .ptr_q(ptr_q)
    );

    typedef struct packed {
        logic       chk;
        logic [2:0] op;
        logic [7:0] arg;
        logic [4:0] dir;
        logic       we;
        logic       clr;
        logic [7:0] wd;
        logic [7:0] erd;
        logic [7:0] eptr;
        logic [3:0] req;
    } vec_t;

    // chk, op, arg, dir, we, clr, wd, expected read, expected pointer after edge, requirement
    localparam vec_t VECS [26] = '{
        '{1, 0, 8'h00, 5'h00, 0, 0, 8'h00, 8'h00, 8'h00, 5},  // R5 null read
        '{1, 0, 8'h00, 5'h00, 1, 0, 8'hAA, 8'h00, 8'h00, 5},  // R5 null write dropped
        '{0, 0, 8'h00, 5'h01, 1, 0, 8'h11, 8'h00, 8'h00, 2},  // R2
        '{1, 0, 8'h00, 5'h01, 0, 0, 8'h00, 8'h11, 8'h00, 14}, // R14 R2
        '{0, 0, 8'h00, 5'h04, 1, 0, 8'h35, 8'h00, 8'h35, 6},  // R6 write pointer slot
        '{1, 0, 8'h00, 5'h04, 0, 0, 8'h00, 8'h35, 8'h35, 6},  // R6 read pointer slot
        '{0, 0, 8'h00, 5'h12, 1, 0, 8'h77, 8'h00, 8'h35, 3},  // R3 byte 0x32
        '{1, 5, 8'h01, 5'h01, 0, 0, 8'h00, 8'h11, 8'h15, 8},  // R8 bank 1
        '{0, 0, 8'h00, 5'h12, 1, 0, 8'h55, 8'h00, 8'h15, 3},  // R3 byte 0x12
        '{1, 2, 8'h05, 5'h12, 0, 0, 8'h00, 8'h55, 8'h35, 9},  // R9 set bit 5
        '{1, 3, 8'h00, 5'h12, 0, 0, 8'h00, 8'h77, 8'h34, 9},  // R9 clear bit 0
        '{0, 0, 8'h00, 5'h02, 1, 0, 8'h66, 8'h00, 8'h34, 6},  // R6 slot 2 storage
        '{1, 1, 8'h32, 5'h02, 0, 0, 8'h00, 8'h66, 8'h34, 7},  // R7 load first cycle
        '{0, 4, 8'h00, 5'h00, 0, 0, 8'h00, 8'h00, 8'h32, 7},  // R7 commit ignores inc
        '{1, 2, 8'h07, 5'h00, 0, 0, 8'h00, 8'h77, 8'hB2, 4},  // R4 indirect read
        '{0, 5, 8'h07, 5'h00, 0, 0, 8'h00, 8'h00, 8'hF2, 8},  // R8 group bit kept
        '{0, 4, 8'h00, 5'h04, 1, 0, 8'h10, 8'h00, 8'hF3, 11}, // R11 op beats slot write
        '{0, 1, 8'hFF, 5'h00, 0, 0, 8'h00, 8'h00, 8'hF3, 7},  // R7
        '{0, 0, 8'h00, 5'h00, 0, 0, 8'h00, 8'h00, 8'hFF, 7},  // R7
        '{1, 4, 8'h00, 5'h04, 0, 0, 8'h00, 8'hFF, 8'h00, 10}, // R10 wrap
        '{0, 0, 8'h00, 5'h04, 1, 0, 8'h09, 8'h00, 8'h09, 6},  // R6
        '{0, 0, 8'h00, 5'h04, 1, 1, 8'h44, 8'h00, 8'h00, 12}, // R12 clear wins on pointer
        '{0, 0, 8'h00, 5'h01, 1, 1, 8'h5A, 8'h00, 8'h00, 12}, // R12 clear wins on storage
        '{1, 0, 8'h00, 5'h01, 0, 0, 8'h00, 8'h00, 8'h00, 12}, // R12
        '{0, 0, 8'h00, 5'h10, 1, 0, 8'h03, 8'h00, 8'h00, 5},  // R5 banked null write
        '{1, 0, 8'h00, 5'h10, 0, 0, 8'h00, 8'h00, 8'h00, 5}   // R5 banked null read
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        dir_addr = '0; wr_en = 0; clr_en = 0; wr_data = '0; ptr_op = 0; ptr_arg = '0;
    endtask

    // Load the pointer with a literal; returns at a falling edge with it in place.
    task automatic load_ptr(input logic [7:0] a);
        @(negedge clk); idle(); ptr_op = 1; ptr_arg = a;
        @(negedge clk); idle();
        @(negedge clk);
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        load_ptr(a);
        dir_addr = 5'h00; wr_en = 1; wr_data = d;
        @(negedge clk); idle();
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        load_ptr(a);
        dir_addr = 5'h00; #1 d = rd_data;
    endtask

    function automatic logic [7:0] pat(input logic [7:0] a);
        return {a[6:0], 1'b1};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int rounds;
        repeat (2) @(posedge clk);
        #1 chk("R1 reset pointer", ptr_q, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // Vector walk
        foreach (VECS[i]) begin
            @(negedge clk);
            ptr_op = VECS[i].op; ptr_arg = VECS[i].arg; dir_addr = VECS[i].dir;
            wr_en = VECS[i].we; clr_en = VECS[i].clr; wr_data = VECS[i].wd;
            #1;
            if (VECS[i].chk) chk($sformatf("R%0d read vec %0d", VECS[i].req, i), rd_data, VECS[i].erd);
            @(posedge clk); #1;
            chk($sformatf("R%0d pointer vec %0d", VECS[i].req, i), ptr_q, VECS[i].eptr);
        end
        idle();

        // R1: reset mid-load drops the staged literal
        @(negedge clk); dir_addr = 5'h04; wr_en = 1; wr_data = 8'h5C;
        @(negedge clk); idle(); ptr_op = 1; ptr_arg = 8'hA7;
        @(negedge clk); idle(); rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk("R1 reset clears pointer", ptr_q, 8'h00);
        @(negedge clk);
        chk("R1 staged load dropped", ptr_q, 8'h00);

        // R13: fill every byte, run the clear loop, read everything back
        for (int a = 1; a < 256; a++) if (a != 4) poke(8'(a), pat(8'(a)));
        load_ptr(8'h10);
        rounds = 0;
        do begin
            dir_addr = 5'h00; clr_en = 1; ptr_op = 4;
            @(negedge clk); idle(); ptr_op = 2; ptr_arg = 8'h04;
            @(negedge clk); idle();
            rounds++;
        end while (ptr_q != 8'h10 && rounds < 300);
        chk("R13 round count", 8'(rounds), 8'd128);
        chk("R13 final pointer", ptr_q, 8'h10);
        for (int a = 1; a < 256; a++) begin
            if (a != 4) begin
                peek(8'(a), d);
                chk($sformatf("R13 byte %02h", a), d, (a & 16) ? 8'h00 : pat(8'(a)));
            end
        end
        idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule